// File: doc/BRIEF.md
# Shared Cache Maintenance Sequencer for Two Threads

Two hardware threads share one cache, and this block carries out their maintenance requests against it. A thread can ask for one of three operations. The first writes back every dirty line and then invalidates the whole cache. The second invalidates the whole cache and discards dirty data. The third flushes the one line that matches an address. A whole-cache operation holds both threads stalled until it completes. A single-line flush holds only the thread that asked for it. When an operation finishes, the block raises a one-cycle broadcast pulse that carries the opcode, so other caching agents can follow.

The cache is modelled only by its line states: valid, dirty and tag, with one line per index (direct mapped). A lookup port fills and reads this state, so the effect of maintenance can be seen from outside. Each thread has its own cache-disable bit, and the two bits are ORed. Dirty lines are written back through a request/done handshake toward memory. The sequencer waits for done on each line before it moves on.

Top module: `cache_maint_seq`

## Requirements
- R1: After reset both stall outputs, the write-back request and the broadcast pulse are low, and every line is invalid, so any lookup misses.
- R2: An address splits into tag (upper TAG_W bits) and index (lower IDX_W bits). A lookup while caching is on and the block is idle hits when the indexed line is valid with an equal tag. A write lookup that hits marks the line dirty. A miss allocates the line, dirty when the lookup is a write.
- R3: Opcode 1 (write back, then invalidate all) visits the lines in index order. For each valid dirty line it holds the write-back request with address {tag, index} until done is seen. Afterwards every line is invalid.
- R4: Opcode 2 (invalidate all) issues no write-back, leaves every line invalid, and stalls for exactly 2^IDX_W + 1 cycles.
- R5: A whole-cache operation stalls both threads from the cycle after acceptance until it completes, whichever thread issued it. Opcode 1 takes 2^IDX_W + 1 cycles plus the done wait of each dirty line.
- R6: Each operation produces exactly one broadcast pulse of one cycle, in the last stalled cycle, with the operation's opcode beside it.
- R7: Opcode 3 (flush line) acts only when the indexed line holds the given tag. A dirty match is written back once and then invalidated, and a clean match is invalidated. Other lines are untouched. Only the requesting thread stalls: 2 cycles, plus the done wait when a write-back is needed.
- R8: When both threads request in the same cycle, thread 0 runs first. Thread 1 stays stalled while its request waits, and it runs straight after.
- R9: The effective disable is the OR of the two per-thread disable bits. While it is set, lookups miss and allocate nothing. Existing lines survive and hit again once caching is re-enabled.
- R10: While an operation is in progress, lookups miss and change nothing. Requests from a thread whose stall is high are ignored, and so is opcode 0.
- R11: A miss onto a valid dirty line leaves that line in place, with no allocation. A miss onto a clean line replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| t0Valid | input | 1 | Thread 0 request strobe |
| t0Op | input | 2 | Thread 0 opcode (1 wb+inv all, 2 inv all, 3 flush line) |
| t0Addr | input | TAG_W+IDX_W | Thread 0 line address for flush |
| t1Valid | input | 1 | Thread 1 request strobe |
| t1Op | input | 2 | Thread 1 opcode |
| t1Addr | input | TAG_W+IDX_W | Thread 1 line address for flush |
| cdBit | input | 2 | Per-thread cache-disable bits |
| lkValid | input | 1 | Lookup strobe |
| lkWrite | input | 1 | Lookup is a store |
| lkAddr | input | TAG_W+IDX_W | Lookup address |
| lkHit | output | 1 | Lookup hit (same cycle) |
| stall | output | 2 | Per-thread stall |
| wbValid | output | 1 | Write-back request toward memory |
| wbAddr | output | TAG_W+IDX_W | Write-back line address |
| wbDone | input | 1 | Memory has taken the write-back |
| bcastPulse | output | 1 | Broadcast to caching agents |
| bcastOp | output | 2 | Opcode carried with the broadcast |

## Verification
The write-back-all walk runs on a cache with a mix of dirty and clean lines. The ordered list of write-back addresses shows that dirty lines are picked out, visited in index order and given the right tags. The same walk run from thread 1 shows that both threads stall, whoever issued it. Invalidate-all runs on a fully dirty cache and must produce no write-back, which tells it apart from the walk. Line flushes aimed at a dirty line, a clean line and a tag mismatch separate the three flush outcomes, and lookups afterwards show which lines survived. Same-cycle requests check the thread 0 priority through the order of the broadcast opcodes.

// File: rtl/cm_pkg.sv
package cm_pkg;

  typedef enum logic [1:0] {
    OP_NONE       = 2'd0,
    OP_WBINV_ALL  = 2'd1,
    OP_INV_ALL    = 2'd2,
    OP_FLUSH_LINE = 2'd3
  } cm_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WALK,
    S_LINE,
    S_WBWAIT,
    S_DONE
  } cm_state_e;

  // Strobes from control to the line store
  typedef struct packed {
    logic invLine;  // clear valid and dirty of the line at walkIdx
    logic busy;     // an operation is in progress, block lookups
  } cm_strobe_t;

endpackage

// File: rtl/cm_line_store.sv
module cm_line_store
  import cm_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cm_strobe_t               strobe,
  input  logic [IDX_W-1:0]         walkIdx,
  input  logic                     cacheOff,
  input  logic                     lkValid,
  input  logic                     lkWrite,
  input  logic [TAG_W+IDX_W-1:0]   lkAddr,
  output logic                     lkHit,
  output logic                     lineValid,
  output logic                     lineDirty,
  output logic [TAG_W-1:0]         lineTag
);

  localparam int LINES = 2 ** IDX_W;

  logic             validQ [LINES];
  logic             dirtyQ [LINES];
  logic [TAG_W-1:0] tagQ   [LINES];

  logic [IDX_W-1:0] lkIdx;
  logic [TAG_W-1:0] lkTag;
  logic             lkActive;
  logic             doAlloc;

  assign lkIdx    = lkAddr[IDX_W-1:0];
  assign lkTag    = lkAddr[TAG_W+IDX_W-1:IDX_W];
  assign lkActive = lkValid && !cacheOff && !strobe.busy;
  assign lkHit    = lkActive && validQ[lkIdx] && (tagQ[lkIdx] == lkTag);
  // a dirty resident line is never displaced by a fill
  assign doAlloc  = lkActive && !lkHit && !(validQ[lkIdx] && dirtyQ[lkIdx]);

  assign lineValid = validQ[walkIdx];
  assign lineDirty = dirtyQ[walkIdx];
  assign lineTag   = tagQ[walkIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        validQ[i] <= 1'b0;
        dirtyQ[i] <= 1'b0;
        tagQ[i]   <= '0;
      end
    end else if (strobe.invLine) begin
      validQ[walkIdx] <= 1'b0;
      dirtyQ[walkIdx] <= 1'b0;
    end else if (lkHit && lkWrite) begin
      dirtyQ[lkIdx] <= 1'b1;
    end else if (doAlloc) begin
      validQ[lkIdx] <= 1'b1;
      dirtyQ[lkIdx] <= lkWrite;
      tagQ[lkIdx]   <= lkTag;
    end
  end

endmodule

// File: rtl/cm_ctrl.sv
module cm_ctrl
  import cm_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     t0Valid,
  input  logic [1:0]               t0Op,
  input  logic [TAG_W+IDX_W-1:0]   t0Addr,
  input  logic                     t1Valid,
  input  logic [1:0]               t1Op,
  input  logic [TAG_W+IDX_W-1:0]   t1Addr,
  input  logic                     lineValid,
  input  logic                     lineDirty,
  input  logic [TAG_W-1:0]         lineTag,
  input  logic                     wbDone,
  output cm_strobe_t               strobe,
  output logic [IDX_W-1:0]         walkIdx,
  output logic [1:0]               stall,
  output logic                     wbValid,
  output logic [TAG_W+IDX_W-1:0]   wbAddr,
  output logic                     bcastPulse,
  output logic [1:0]               bcastOp
);

  localparam int ADDR_W = TAG_W + IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(2 ** IDX_W - 1);

  cm_state_e          state;
  cm_op_e             curOp;
  logic               curThread;
  logic [TAG_W-1:0]   curTag;
  logic [IDX_W-1:0]   idx;
  logic [ADDR_W-1:0]  wbAddrQ;

  logic               pendValid;
  logic               pendThread;
  cm_op_e             pendOp;
  logic [ADDR_W-1:0]  pendAddr;

  // per-thread request views
  logic               reqLive [2];
  cm_op_e             reqOp   [2];
  logic [ADDR_W-1:0]  reqAddr [2];

  assign reqOp[0]   = cm_op_e'(t0Op);
  assign reqOp[1]   = cm_op_e'(t1Op);
  assign reqAddr[0] = t0Addr;
  assign reqAddr[1] = t1Addr;

  generate
    for (genvar t = 0; t < 2; t++) begin : g_thr
      logic reqStrobe;
      assign reqStrobe = (t == 0) ? t0Valid : t1Valid;
      assign reqLive[t] = reqStrobe && (reqOp[t] != OP_NONE) && !stall[t];
      assign stall[t] = ((state != S_IDLE) &&
                         ((curOp != OP_FLUSH_LINE) || (curThread == 1'(t)))) ||
                        (pendValid && (pendThread == 1'(t)));
    end
  endgenerate

  // arbitration of the single execution slot and the single wait slot
  logic              slotFree;
  logic              startNow;
  cm_op_e            startOp;
  logic              startThread;
  logic [ADDR_W-1:0] startAddr;
  logic              pendClr;
  logic              pendSet;
  logic              pendSetThread;

  assign slotFree = (state == S_IDLE) || (state == S_DONE);

  always_comb begin
    startNow      = 1'b0;
    startOp       = OP_NONE;
    startThread   = 1'b0;
    startAddr     = '0;
    pendClr       = 1'b0;
    pendSet       = 1'b0;
    pendSetThread = 1'b0;
    if (slotFree) begin
      if (pendValid) begin
        startNow    = 1'b1;
        startOp     = pendOp;
        startThread = pendThread;
        startAddr   = pendAddr;
        pendClr     = 1'b1;
      end else if (reqLive[0]) begin
        startNow    = 1'b1;
        startOp     = reqOp[0];
        startThread = 1'b0;
        startAddr   = reqAddr[0];
        if (reqLive[1]) begin
          pendSet       = 1'b1;
          pendSetThread = 1'b1;
        end
      end else if (reqLive[1]) begin
        startNow    = 1'b1;
        startOp     = reqOp[1];
        startThread = 1'b1;
        startAddr   = reqAddr[1];
      end
    end else if (reqLive[0]) begin
      pendSet       = 1'b1;
      pendSetThread = 1'b0;
    end else if (reqLive[1]) begin
      pendSet       = 1'b1;
      pendSetThread = 1'b1;
    end
  end

  // per-line decisions
  logic needWb;
  logic lineMatch;

  assign needWb    = (curOp == OP_WBINV_ALL) && lineValid && lineDirty;
  assign lineMatch = lineValid && (lineTag == curTag);

  always_comb begin
    strobe.busy    = (state != S_IDLE);
    strobe.invLine = 1'b0;
    unique case (state)
      S_WALK:   strobe.invLine = !needWb;
      S_LINE:   strobe.invLine = lineMatch && !lineDirty;
      S_WBWAIT: strobe.invLine = wbDone;
      default:  strobe.invLine = 1'b0;
    endcase
  end

  assign walkIdx    = idx;
  assign wbValid    = (state == S_WBWAIT);
  assign wbAddr     = wbAddrQ;
  assign bcastPulse = (state == S_DONE);
  assign bcastOp    = (state == S_DONE) ? curOp : OP_NONE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      curOp      <= OP_NONE;
      curThread  <= 1'b0;
      curTag     <= '0;
      idx        <= '0;
      wbAddrQ    <= '0;
      pendValid  <= 1'b0;
      pendThread <= 1'b0;
      pendOp     <= OP_NONE;
      pendAddr   <= '0;
    end else begin
      unique case (state)
        S_WALK: begin
          if (needWb) begin
            wbAddrQ <= {lineTag, idx};
            state   <= S_WBWAIT;
          end else if (idx == LAST_IDX) begin
            state <= S_DONE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_LINE: begin
          if (lineMatch && lineDirty) begin
            wbAddrQ <= {curTag, idx};
            state   <= S_WBWAIT;
          end else begin
            state <= S_DONE;
          end
        end
        S_WBWAIT: begin
          if (wbDone) begin
            if ((curOp == OP_FLUSH_LINE) || (idx == LAST_IDX)) begin
              state <= S_DONE;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_WALK;
            end
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase

      if (startNow) begin
        state     <= (startOp == OP_FLUSH_LINE) ? S_LINE : S_WALK;
        curOp     <= startOp;
        curThread <= startThread;
        curTag    <= startAddr[ADDR_W-1:IDX_W];
        idx       <= (startOp == OP_FLUSH_LINE) ? startAddr[IDX_W-1:0] : '0;
      end

      if (pendClr) pendValid <= 1'b0;
      if (pendSet) begin
        pendValid  <= 1'b1;
        pendThread <= pendSetThread;
        pendOp     <= reqOp[pendSetThread];
        pendAddr   <= reqAddr[pendSetThread];
      end
    end
  end

endmodule

// File: rtl/cache_maint_seq.sv
module cache_maint_seq
  import cm_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   t0Valid,
  input  logic [1:0]             t0Op,
  input  logic [TAG_W+IDX_W-1:0] t0Addr,
  input  logic                   t1Valid,
  input  logic [1:0]             t1Op,
  input  logic [TAG_W+IDX_W-1:0] t1Addr,
  input  logic [1:0]             cdBit,
  input  logic                   lkValid,
  input  logic                   lkWrite,
  input  logic [TAG_W+IDX_W-1:0] lkAddr,
  output logic                   lkHit,
  output logic [1:0]             stall,
  output logic                   wbValid,
  output logic [TAG_W+IDX_W-1:0] wbAddr,
  input  logic                   wbDone,
  output logic                   bcastPulse,
  output logic [1:0]             bcastOp
);

  cm_strobe_t       strobe;
  logic [IDX_W-1:0] walkIdx;
  logic             lineValid;
  logic             lineDirty;
  logic [TAG_W-1:0] lineTag;
  logic             cacheOff;

  // either thread's disable bit turns caching off for both
  assign cacheOff = |cdBit;

  cm_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .t0Valid    (t0Valid),
    .t0Op       (t0Op),
    .t0Addr     (t0Addr),
    .t1Valid    (t1Valid),
    .t1Op       (t1Op),
    .t1Addr     (t1Addr),
    .lineValid  (lineValid),
    .lineDirty  (lineDirty),
    .lineTag    (lineTag),
    .wbDone     (wbDone),
    .strobe     (strobe),
    .walkIdx    (walkIdx),
    .stall      (stall),
    .wbValid    (wbValid),
    .wbAddr     (wbAddr),
    .bcastPulse (bcastPulse),
    .bcastOp    (bcastOp)
  );

  cm_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .walkIdx   (walkIdx),
    .cacheOff  (cacheOff),
    .lkValid   (lkValid),
    .lkWrite   (lkWrite),
    .lkAddr    (lkAddr),
    .lkHit     (lkHit),
    .lineValid (lineValid),
    .lineDirty (lineDirty),
    .lineTag   (lineTag)
  );

endmodule

// File: rtl/cm_checker.sv
module cm_checker #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [1:0]             cdBit,
  input logic                   lkHit,
  input logic [1:0]             stall,
  input logic                   wbValid,
  input logic [TAG_W+IDX_W-1:0] wbAddr,
  input logic                   wbDone,
  input logic                   bcastPulse,
  input logic [1:0]             bcastOp
);

  p_wb_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbDone) |=> (wbValid && $stable(wbAddr)));

  p_release_t0_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall[0]) |-> $past(bcastPulse));

  p_release_t1_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall[1]) |-> $past(bcastPulse));

  p_bcast_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    bcastPulse |=> !bcastPulse);

  p_bcast_stalled_r6: assert property (@(posedge clk) disable iff (!rstN)
    bcastPulse |-> ((stall != 2'b00) && (bcastOp != 2'b00)));

  p_off_miss_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cdBit != 2'b00) |-> !lkHit);

  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stall == 2'b00) |-> (!wbValid && !bcastPulse));

endmodule

bind cache_maint_seq cm_checker #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cdBit      (cdBit),
  .lkHit      (lkHit),
  .stall      (stall),
  .wbValid    (wbValid),
  .wbAddr     (wbAddr),
  .wbDone     (wbDone),
  .bcastPulse (bcastPulse),
  .bcastOp    (bcastOp)
);

// File: tb/tb_cache_maint_seq.sv
`timescale 1ns/1ps
module tb_cache_maint_seq;

  localparam int IDX_W  = 3;
  localparam int TAG_W  = 8;
  localparam int ADDR_W = TAG_W + IDX_W;
  localparam int LINES  = 2 ** IDX_W;
  localparam int WB_LAT = 2;

  logic              clk = 1'b0;
  logic              rstN;
  logic              t0Valid, t1Valid;
  logic [1:0]        t0Op, t1Op;
  logic [ADDR_W-1:0] t0Addr, t1Addr;
  logic [1:0]        cdBit;
  logic              lkValid, lkWrite;
  logic [ADDR_W-1:0] lkAddr;
  logic              lkHit;
  logic [1:0]        stall;
  logic              wbValid;
  logic [ADDR_W-1:0] wbAddr;
  logic              wbDone;
  logic              bcastPulse;
  logic [1:0]        bcastOp;

  always #5 clk = ~clk;

  cache_maint_seq #(.IDX_W(IDX_W), .TAG_W(TAG_W)) dut (
    .clk(clk), .rstN(rstN),
    .t0Valid(t0Valid), .t0Op(t0Op), .t0Addr(t0Addr),
    .t1Valid(t1Valid), .t1Op(t1Op), .t1Addr(t1Addr),
    .cdBit(cdBit), .lkValid(lkValid), .lkWrite(lkWrite), .lkAddr(lkAddr),
    .lkHit(lkHit), .stall(stall), .wbValid(wbValid), .wbAddr(wbAddr),
    .wbDone(wbDone), .bcastPulse(bcastPulse), .bcastOp(bcastOp)
  );

  int nChecks = 0;
  int nFail   = 0;
  int st0, st1;
  int wbCount, bcCount, wbWait;
  logic [ADDR_W-1:0] wbLog [16];
  logic [1:0]        bcLog [8];
  bit finished = 1'b0;

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx);
    return {TAG_W'(tag), IDX_W'(idx)};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clrMon();
    st0 = 0; st1 = 0; wbCount = 0; bcCount = 0;
  endtask

  // memory side: answers each write-back after WB_LAT cycles
  initial begin
    wbDone = 1'b0;
    wbWait = 0;
    forever begin
      @(negedge clk);
      if (wbDone) wbDone = 1'b0;
      else if (wbValid && rstN) begin
        wbWait++;
        if (wbWait >= WB_LAT) begin
          wbWait = 0;
          wbDone = 1'b1;
          if (wbCount < 16) wbLog[wbCount] = wbAddr;
          wbCount++;
        end
      end
    end
  end

  // stall and broadcast monitor, sampled after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (stall[0]) st0++;
      if (stall[1]) st1++;
      if (bcastPulse) begin
        if (bcCount < 8) bcLog[bcCount] = bcastOp;
        bcCount++;
      end
    end
  end

  task automatic access(input logic [ADDR_W-1:0] a, input logic wr, output logic hit);
    @(negedge clk);
    lkValid = 1'b1; lkAddr = a; lkWrite = wr;
    #1 hit = lkHit;
    @(posedge clk);
    #1 lkValid = 1'b0; lkWrite = 1'b0;
  endtask

  task automatic issue(input int thr, input logic [1:0] op, input logic [ADDR_W-1:0] a, input bit clr);
    @(negedge clk);
    if (clr) clrMon();
    if (thr == 0) begin t0Valid = 1'b1; t0Op = op; t0Addr = a; end
    else          begin t1Valid = 1'b1; t1Op = op; t1Addr = a; end
    @(negedge clk);
    t0Valid = 1'b0; t1Valid = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (2) @(negedge clk);
    while (stall != 2'b00) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    logic h;
    chk("R1", "stall", int'(stall), 0);
    chk("R1", "wbValid", int'(wbValid), 0);
    chk("R1", "bcastPulse", int'(bcastPulse), 0);
    access(mk(8'h10, 0), 1'b0, h);
    chk("R1", "lookup after reset", int'(h), 0);
  endtask

  task automatic testLookup();
    logic h;
    access(mk(8'h10, 0), 1'b0, h);
    chk("R2", "hit after allocate", int'(h), 1);
    access(mk(8'h10, 0), 1'b1, h);
    chk("R2", "write hit", int'(h), 1);
    access(mk(8'h11, 0), 1'b0, h);
    chk("R2", "other tag misses", int'(h), 0);
  endtask

  task automatic testWbInvAll();
    logic h;
    int hits = 0;
    for (int i = 1; i < LINES; i++) access(mk(8'h10 + i, i), logic'(i % 2), h);
    issue(1, 2'd1, '0, 1'b1);
    waitIdle();
    chk("R3", "write-back count", wbCount, 5);
    for (int k = 0; k < 5; k++)
      chk("R3", "write-back address order", int'(wbLog[k]),
          int'(mk(8'h10 + (k == 0 ? 0 : 2*k-1), (k == 0 ? 0 : 2*k-1))));
    chk("R5", "thread0 stall cycles", st0, LINES + 5*WB_LAT + 1);
    chk("R5", "thread1 stall cycles", st1, LINES + 5*WB_LAT + 1);
    chk("R6", "broadcast count", bcCount, 1);
    chk("R6", "broadcast opcode", int'(bcLog[0]), 1);
    for (int i = 0; i < LINES; i++) begin
      access(mk(8'h10 + i, i), 1'b0, h);
      hits += int'(h);
    end
    chk("R3", "hits after invalidate", hits, 0);
  endtask

  task automatic testInvAll();
    logic h;
    int hits = 0;
    for (int i = 0; i < LINES; i++) access(mk(8'h20 + i, i), 1'b1, h);
    issue(0, 2'd2, '0, 1'b1);
    waitIdle();
    chk("R4", "no write-back", wbCount, 0);
    chk("R4", "stall cycles", st0, LINES + 1);
    chk("R5", "other thread stalled", st1, LINES + 1);
    chk("R6", "broadcast opcode", int'(bcLog[0]), 2);
    for (int i = 0; i < LINES; i++) begin
      access(mk(8'h20 + i, i), 1'b0, h);
      hits += int'(h);
    end
    chk("R4", "hits after invalidate", hits, 0);
  endtask

  task automatic testFlushLine();
    logic h;
    access(mk(8'h23, 3), 1'b1, h);           // make line 3 dirty
    issue(1, 2'd3, mk(8'h23, 3), 1'b1);
    waitIdle();
    chk("R7", "dirty flush write-backs", wbCount, 1);
    chk("R7", "dirty flush address", int'(wbLog[0]), int'(mk(8'h23, 3)));
    chk("R7", "requester stall", st1, 2 + WB_LAT);
    chk("R7", "other thread free", st0, 0);
    chk("R6", "flush broadcast opcode", int'(bcLog[0]), 3);
    issue(0, 2'd3, mk(8'h25, 5), 1'b1);
    waitIdle();
    chk("R7", "clean flush write-backs", wbCount, 0);
    chk("R7", "clean flush stall", st0, 2);
    issue(0, 2'd3, mk(8'h99, 4), 1'b1);
    waitIdle();
    chk("R6", "mismatch flush broadcast", bcCount, 1);
    access(mk(8'h24, 4), 1'b0, h);
    chk("R7", "tag mismatch leaves line", int'(h), 1);
    access(mk(8'h26, 6), 1'b0, h);
    chk("R7", "neighbour untouched", int'(h), 1);
    access(mk(8'h23, 3), 1'b0, h);
    chk("R7", "dirty line invalidated", int'(h), 0);
    access(mk(8'h25, 5), 1'b0, h);
    chk("R7", "clean line invalidated", int'(h), 0);
  endtask

  task automatic testArbitration();
    @(negedge clk);
    clrMon();
    t0Valid = 1'b1; t0Op = 2'd2; t0Addr = '0;
    t1Valid = 1'b1; t1Op = 2'd3; t1Addr = mk(8'h26, 6);
    @(negedge clk);
    t0Valid = 1'b0; t1Valid = 1'b0;
    waitIdle();
    chk("R8", "two broadcasts", bcCount, 2);
    chk("R8", "thread0 first", int'(bcLog[0]), 2);
    chk("R8", "thread1 second", int'(bcLog[1]), 3);
    chk("R8", "thread0 stall", st0, LINES + 1);
    chk("R8", "thread1 held while waiting", st1, LINES + 3);
  endtask

  task automatic testDisable();
    logic h;
    access(mk(8'h30, 2), 1'b0, h);
    cdBit = 2'b10;
    access(mk(8'h30, 2), 1'b0, h);
    chk("R9", "thread1 disable forces miss", int'(h), 0);
    access(mk(8'h31, 6), 1'b0, h);
    cdBit = 2'b01;
    access(mk(8'h30, 2), 1'b0, h);
    chk("R9", "thread0 disable forces miss", int'(h), 0);
    cdBit = 2'b00;
    access(mk(8'h30, 2), 1'b0, h);
    chk("R9", "line survives disable", int'(h), 1);
    access(mk(8'h31, 6), 1'b0, h);
    chk("R9", "no allocation while disabled", int'(h), 0);
  endtask

  task automatic testBusy();
    logic h;
    issue(0, 2'd2, '0, 1'b1);
    access(mk(8'h30, 2), 1'b0, h);
    chk("R10", "lookup during operation", int'(h), 0);
    issue(0, 2'd1, '0, 1'b0);                 // thread 0 is stalled
    waitIdle();
    chk("R10", "stalled request ignored", bcCount, 1);
    chk("R10", "no write-back from ignored request", wbCount, 0);
    issue(1, 2'd0, '0, 1'b1);
    waitIdle();
    chk("R10", "opcode zero ignored", bcCount, 0);
  endtask

  task automatic testDirtyConflict();
    logic h;
    access(mk(8'h50, 4), 1'b1, h);
    access(mk(8'h51, 4), 1'b0, h);
    chk("R11", "miss on dirty line", int'(h), 0);
    access(mk(8'h50, 4), 1'b0, h);
    chk("R11", "dirty line kept", int'(h), 1);
    access(mk(8'h60, 1), 1'b0, h);
    access(mk(8'h61, 1), 1'b0, h);
    access(mk(8'h61, 1), 1'b0, h);
    chk("R11", "clean line replaced", int'(h), 1);
    access(mk(8'h60, 1), 1'b0, h);
    chk("R11", "old clean tag gone", int'(h), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    t0Valid = 1'b0; t1Valid = 1'b0; t0Op = '0; t1Op = '0; t0Addr = '0; t1Addr = '0;
    cdBit = 2'b00; lkValid = 1'b0; lkWrite = 1'b0; lkAddr = '0;
    clrMon();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLookup();
    testWbInvAll();
    testInvAll();
    testFlushLine();
    testArbitration();
    testDisable();
    testBusy();
    testDirtyConflict();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule